// File: doc/BRIEF.md
# Shared Issue Queue Entry Budget Manager

This block keeps the entry budget of an issue queue that several hardware threads share. It does not hold any instructions. It counts how many queue slots each thread holds and how many slots are still free overall. It also keeps a per-thread ceiling (the cap), which a static sharing policy sets. Dispatch logic reads the full flags and free counts before it sends an instruction, and it raises an allocate pulse tagged with the thread. Issue, completion and squash logic send release pulses back to the block.

There are three sharing policies:
- **Dynamic:** every thread may use the whole queue.
- **Partitioned:** the queue is split evenly between threads.
- **Threshold:** each thread is limited to a configured percentage of the queue.

The caps are loaded on the first clock after reset. They are recomputed when the set of active threads changes: for an even split under partitioned sharing, and for a single surviving thread under threshold sharing.

A release carries a kind code. An issued non-memory instruction gives its slot back at once. An issued memory instruction keeps its slot until it completes. Squashed entries come back on a separate pulse, and that pulse may arrive in the same cycle as an ordinary release.

Top module: `iq_share_budget`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, global free equals TOTAL and global full is low. Every cap is zero, so every thread reports free 0 and full high. The error flag is low. On that first edge the caps take their policy base values.
- R2: The policy input is a 2-bit code. Code 0 selects dynamic sharing, and code 3 behaves the same way. Under dynamic sharing each base cap equals TOTAL, and a change of active set leaves every cap unchanged.
- R3: Policy code 1 selects partitioned sharing, with base cap floor(TOTAL/NT). When the active mask changes to a non-empty set, each active thread's cap becomes floor(TOTAL/number of active threads). Inactive threads keep their caps, and an empty mask changes no cap. The new caps are visible one clock after the change.
- R4: Policy code 2 selects threshold sharing, with base cap floor(TOTAL*p/100), where p is the percentage input clamped to 100. When the mask changes to exactly one active thread, that thread's cap becomes TOTAL. Any other mask change leaves the caps unchanged.
- R5: A thread's free count is its cap minus its occupancy, or 0 when the occupancy is at or above the cap. The thread's full flag is high exactly when its free count is 0.
- R6: An accepted allocate raises that thread's occupancy by one and lowers global free by one, both visible after the clock edge. Global full is high exactly when global free is 0.
- R7: An allocate that arrives while global full or the tagged thread's full flag is high is dropped, with no change to any count. The error output is then high for exactly the following cycle.
- R8: Release kind codes are as follows. Code 0 (issued non-memory) and code 2 (memory completion) free one entry of the tagged thread. Code 1 (issued memory) and code 3 change nothing.
- R9: A squash pulse frees one entry of its thread. A squash and a freeing release for the same thread in one cycle free two entries. Releases beyond the thread's current occupancy are ignored.
- R10: Global free plus the sum of all thread occupancies always equals TOTAL, including in cycles where an allocate and releases happen together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Sharing policy code: 0/3 dynamic, 1 partitioned, 2 threshold |
| pct_i | input | 7 | Threshold percentage, clamped to 100 |
| act_mask_i | input | NT | Active thread mask |
| alloc_vld_i | input | 1 | Allocate pulse |
| alloc_tid_i | input | TW | Thread of the allocate |
| rel_vld_i | input | 1 | Release pulse |
| rel_tid_i | input | TW | Thread of the release |
| rel_kind_i | input | 2 | Release kind code |
| sq_vld_i | input | 1 | Squash release pulse |
| sq_tid_i | input | TW | Thread of the squash release |
| glob_free_o | output | CW | Global free entry count |
| glob_full_o | output | 1 | Global queue full |
| thr_full_o | output | NT | Per-thread full flags |
| thr_free_o | output | NT*CW | Per-thread free counts, thread t at bits t*CW upward |
| alloc_err_o | output | 1 | Dropped allocate indication |

## Verification
If a thread's occupancy register goes wrong, that thread's free count moves by the same amount after the next edge. If the global counter drifts instead, global free and global full move on their own. In either case the global count and the per-thread counts stop adding up to the queue size, and that shows at the ports within one cycle of the faulty update.

A wrong cap shows only as a wrong per-thread free count, in the cycle after the initial load or after a mask change. Because of this, the test reads every free count after each mask transition, and keeps holding threads near their caps so that drops show up on the error flag.

// File: rtl/iqcap_pkg.sv
package iqcap_pkg;

  typedef enum logic [1:0] {
    POL_DYN  = 2'd0,
    POL_PART = 2'd1,
    POL_THR  = 2'd2,
    POL_RSV  = 2'd3
  } share_pol_e;

  typedef enum logic [1:0] {
    RK_ISSUE_ALU = 2'd0,
    RK_ISSUE_MEM = 2'd1,
    RK_MEM_DONE  = 2'd2,
    RK_NOP       = 2'd3
  } rel_kind_e;

  function automatic logic kind_frees(input logic [1:0] k);
    return (k == RK_ISSUE_ALU) || (k == RK_MEM_DONE);
  endfunction

endpackage

// File: rtl/iqcap_caps.sv
module iqcap_caps
  import iqcap_pkg::*;
#(
  parameter int NT    = 4,
  parameter int TOTAL = 32,
  parameter int CW    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             policy_i,
  input  logic [6:0]             pct_i,
  input  logic [NT-1:0]          mask_i,
  output logic [NT-1:0][CW-1:0]  cap_o
);

  logic                  init_q;
  logic [NT-1:0]         mask_q;
  logic [NT-1:0][CW-1:0] cap_q;
  logic [NT-1:0][CW-1:0] cap_d;
  logic                  cap_en;
  logic [6:0]            pct_c;
  logic [CW-1:0]         base_cap;
  logic [CW-1:0]         share_cap;
  int                    act_n;

  always_comb begin
    pct_c = (pct_i > 7'd100) ? 7'd100 : pct_i;
    act_n = 0;
    for (int t = 0; t < NT; t++) act_n += int'(mask_i[t]);
    case (share_pol_e'(policy_i))
      POL_PART: base_cap = CW'(TOTAL / NT);
      POL_THR:  base_cap = CW'((TOTAL * int'(pct_c)) / 100);
      default:  base_cap = CW'(TOTAL);
    endcase
    share_cap = (act_n == 0) ? CW'(TOTAL) : CW'(TOTAL / act_n);
  end

  always_comb begin
    cap_d  = cap_q;
    cap_en = !init_q || (mask_i != mask_q);
    if (!init_q) begin
      for (int t = 0; t < NT; t++) cap_d[t] = base_cap;
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (mask_i[t]) begin
          if (policy_i == POL_PART && act_n != 0) cap_d[t] = share_cap;
          else if (policy_i == POL_THR && act_n == 1) cap_d[t] = CW'(TOTAL);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0;
      mask_q <= '0;
      cap_q  <= '0;
    end else if (cap_en) begin
      init_q <= 1'b1;
      mask_q <= mask_i;
      cap_q  <= cap_d;
    end
  end

  assign cap_o = cap_q;

  // R3
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && (mask_i == mask_q)) |=> $stable(cap_q));

  // R2
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> ($countones(mask_q) >= 0 && cap_q[0] <= CW'(TOTAL)));

endmodule

// File: rtl/iqcap_thread.sv
module iqcap_thread #(
  parameter int TOTAL = 32,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cap_i,
  input  logic          inc_i,
  input  logic          rel_i,
  input  logic          sq_i,
  output logic [CW-1:0] occ_o,
  output logic [CW-1:0] free_o,
  output logic          full_o,
  output logic [1:0]    dec_o
);

  logic [CW-1:0] occ_q;
  logic [CW-1:0] occ_d;
  logic [1:0]    dec_req;
  logic [1:0]    dec_eff;
  logic          occ_en;

  always_comb begin
    dec_req = {1'b0, rel_i} + {1'b0, sq_i};
    dec_eff = (occ_q < CW'(dec_req)) ? occ_q[1:0] : dec_req;
    occ_d   = occ_q - CW'(dec_eff) + CW'(inc_i);
    occ_en  = inc_i || (dec_eff != 2'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  assign occ_o  = occ_q;
  assign dec_o  = dec_eff;
  assign free_o = (cap_i > occ_q) ? (cap_i - occ_q) : '0;
  assign full_o = (free_o == '0);

  // R6
  occ_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q > $past(occ_q)) |-> $past(inc_i));

  // R9
  occ_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q < $past(occ_q)) |-> ($past(rel_i) || $past(sq_i)));

  // R9
  occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q + 2'd2 >= $past(occ_q)) && (occ_q <= CW'(TOTAL)));

endmodule

// File: rtl/iqcap_pool.sv
module iqcap_pool #(
  parameter int NT    = 4,
  parameter int TOTAL = 32,
  parameter int CW    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_i,
  input  logic [NT-1:0][1:0]   give_i,
  output logic [CW-1:0]        free_o,
  output logic                 full_o
);

  logic [CW-1:0] free_q;
  logic [CW-1:0] free_d;
  logic          free_en;
  int            give_n;

  always_comb begin
    give_n = 0;
    for (int t = 0; t < NT; t++) give_n += int'(give_i[t]);
    free_d  = CW'(int'(free_q) + give_n - int'(take_i));
    free_en = take_i || (give_n != 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= CW'(TOTAL);
    else if (free_en) free_q <= free_d;
  end

  assign free_o = free_q;
  assign full_o = (free_q == '0);

  // R6
  gfree_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= CW'(TOTAL));

  // R6
  gfree_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q < $past(free_q)) |-> $past(take_i));

endmodule

// File: rtl/iq_share_budget.sv
module iq_share_budget
  import iqcap_pkg::*;
#(
  parameter int NT    = 4,
  parameter int TOTAL = 32,
  parameter int CW    = $clog2(TOTAL + 1),
  parameter int TW    = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy_i,
  input  logic [6:0]       pct_i,
  input  logic [NT-1:0]    act_mask_i,
  input  logic             alloc_vld_i,
  input  logic [TW-1:0]    alloc_tid_i,
  input  logic             rel_vld_i,
  input  logic [TW-1:0]    rel_tid_i,
  input  logic [1:0]       rel_kind_i,
  input  logic             sq_vld_i,
  input  logic [TW-1:0]    sq_tid_i,
  output logic [CW-1:0]    glob_free_o,
  output logic             glob_full_o,
  output logic [NT-1:0]    thr_full_o,
  output logic [NT*CW-1:0] thr_free_o,
  output logic             alloc_err_o
);

  localparam int SW = CW + TW + 1;

  logic [NT-1:0][CW-1:0] cap_w;
  logic [NT-1:0][CW-1:0] occ_w;
  logic [NT-1:0][CW-1:0] free_w;
  logic [NT-1:0][1:0]    dec_w;
  logic [NT-1:0]         full_w;
  logic                  alloc_acc;
  logic                  err_q;
  logic                  err_d;
  logic                  rel_frees;
  logic [SW-1:0]         occ_sum;

  iqcap_caps #(.NT(NT), .TOTAL(TOTAL), .CW(CW)) u_caps (
    .clk      (clk),
    .rst_n    (rst_n),
    .policy_i (policy_i),
    .pct_i    (pct_i),
    .mask_i   (act_mask_i),
    .cap_o    (cap_w)
  );

  always_comb begin
    rel_frees = rel_vld_i && kind_frees(rel_kind_i);
    alloc_acc = alloc_vld_i && !glob_full_o && !full_w[alloc_tid_i];
    err_d     = alloc_vld_i && !alloc_acc;
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    iqcap_thread #(.TOTAL(TOTAL), .CW(CW)) u_thr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (cap_w[t]),
      .inc_i  (alloc_acc && (alloc_tid_i == TW'(t))),
      .rel_i  (rel_frees && (rel_tid_i == TW'(t))),
      .sq_i   (sq_vld_i && (sq_tid_i == TW'(t))),
      .occ_o  (occ_w[t]),
      .free_o (free_w[t]),
      .full_o (full_w[t]),
      .dec_o  (dec_w[t])
    );
    assign thr_free_o[t*CW +: CW] = free_w[t];
  end

  iqcap_pool #(.NT(NT), .TOTAL(TOTAL), .CW(CW)) u_pool (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (alloc_acc),
    .give_i (dec_w),
    .free_o (glob_free_o),
    .full_o (glob_full_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign alloc_err_o = err_q;
  assign thr_full_o  = full_w;

  always_comb begin
    occ_sum = '0;
    for (int t = 0; t < NT; t++) occ_sum += SW'(occ_w[t]);
  end

  // R10
  pool_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SW'(glob_free_o) + occ_sum) == SW'(TOTAL));

  // R7
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err_o |-> $past(alloc_vld_i));

  // R7
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err_o |-> (glob_free_o >= $past(glob_free_o)));

endmodule

// File: tb/sim_iq_share_budget.sv
module sim_iq_share_budget;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  policy;
  logic [6:0]  pct;
  logic [3:0]  mask;
  logic        alloc_vld, rel_vld, sq_vld;
  logic [1:0]  alloc_tid, rel_tid, sq_tid, rel_kind;
  logic [5:0]  glob_free;
  logic        glob_full, alloc_err;
  logic [3:0]  thr_full;
  logic [23:0] thr_free;

  always #4 clk = ~clk;

  iq_share_budget u0 (
    .clk(clk), .rst_n(rst_n), .policy_i(policy), .pct_i(pct),
    .act_mask_i(mask), .alloc_vld_i(alloc_vld), .alloc_tid_i(alloc_tid),
    .rel_vld_i(rel_vld), .rel_tid_i(rel_tid), .rel_kind_i(rel_kind),
    .sq_vld_i(sq_vld), .sq_tid_i(sq_tid), .glob_free_o(glob_free),
    .glob_full_o(glob_full), .thr_full_o(thr_full), .thr_free_o(thr_free),
    .alloc_err_o(alloc_err)
  );

  typedef struct packed {
    logic [5:0]  gfree;
    logic        gfull;
    logic [3:0]  tfull;
    logic [23:0] tfree;
    logic        err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    vectors = 0;
  int    miscompares = 0;

  int m_cap[4];
  int m_occ[4];
  int m_gfree;
  int m_init;
  int m_err;
  logic [3:0] m_mask;

  function automatic exp_t model_view();
    exp_t e;
    e.gfree = 6'(m_gfree);
    e.gfull = (m_gfree == 0);
    e.err   = m_err[0];
    for (int t = 0; t < 4; t++) begin
      int f = (m_cap[t] > m_occ[t]) ? m_cap[t] - m_occ[t] : 0;
      e.tfree[t*6 +: 6] = 6'(f);
      e.tfull[t] = (f == 0);
    end
    return e;
  endfunction

  task automatic compare(input exp_t e, input string tg);
    exp_t a;
    a.gfree = glob_free; a.gfull = glob_full; a.tfull = thr_full;
    a.tfree = thr_free;  a.err = alloc_err;
    vectors++;
    if (a !== e) begin
      miscompares++;
      $display("FAIL %s: actual gfree=%0d gfull=%0b tfull=%b tfree=%h err=%0b expected gfree=%0d gfull=%0b tfull=%b tfree=%h err=%0b",
               tg, a.gfree, a.gfull, a.tfull, a.tfree, a.err,
               e.gfree, e.gfull, e.tfull, e.tfree, e.err);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() != 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  function automatic int base_cap();
    int pc = (pct > 7'd100) ? 100 : int'(pct);
    if (policy == 2'd1) return 32 / 4;
    if (policy == 2'd2) return (32 * pc) / 100;
    return 32;
  endfunction

  task automatic idle_inputs();
    alloc_vld = 0; rel_vld = 0; sq_vld = 0;
    alloc_tid = 0; rel_tid = 0; sq_tid = 0; rel_kind = 2'd3;
  endtask

  task automatic do_reset(input int pol, input int pc, input logic [3:0] mk);
    @(posedge clk); #1;
    rst_n = 0; policy = 2'(pol); pct = 7'(pc); mask = mk;
    idle_inputs();
    for (int t = 0; t < 4; t++) begin m_cap[t] = 0; m_occ[t] = 0; end
    m_gfree = 32; m_init = 0; m_err = 0; m_mask = 4'h0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    compare(model_view(), "R1");
  endtask

  task automatic step(input bit a, input int at, input bit r, input int rt,
                      input int rk, input bit s, input int st, input string tg);
    int tf[4];
    int acc;
    alloc_vld = a; alloc_tid = 2'(at);
    rel_vld = r; rel_tid = 2'(rt); rel_kind = 2'(rk);
    sq_vld = s; sq_tid = 2'(st);
    for (int t = 0; t < 4; t++) tf[t] = (m_cap[t] > m_occ[t]) ? m_cap[t] - m_occ[t] : 0;
    acc   = (a && m_gfree != 0 && tf[at] != 0) ? 1 : 0;
    m_err = (a && acc == 0) ? 1 : 0;
    for (int t = 0; t < 4; t++) begin
      int dreq = ((r && rt == t && (rk == 0 || rk == 2)) ? 1 : 0) + ((s && st == t) ? 1 : 0);
      int dec  = (dreq > m_occ[t]) ? m_occ[t] : dreq;
      m_occ[t] = m_occ[t] - dec + ((acc == 1 && at == t) ? 1 : 0);
      m_gfree  = m_gfree + dec;
    end
    m_gfree = m_gfree - acc;
    if (m_init == 0) begin
      m_init = 1; m_mask = mask;
      for (int t = 0; t < 4; t++) m_cap[t] = base_cap();
    end else if (mask != m_mask) begin
      int n = $countones(mask);
      m_mask = mask;
      for (int t = 0; t < 4; t++) begin
        if (mask[t]) begin
          if (policy == 2'd1 && n != 0) m_cap[t] = 32 / n;
          else if (policy == 2'd2 && n == 1) m_cap[t] = 32;
        end
      end
    end
    @(posedge clk); #1;
    exp_q.push_back(model_view());
    tag_q.push_back(tg);
    @(negedge clk);
  endtask

  task automatic nop(input string tg);
    step(0, 0, 0, 0, 3, 0, 0, tg);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R1: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // dynamic sharing
    do_reset(0, 0, 4'hF);
    nop("R2");
    for (int i = 0; i < 30; i++) step(1, 0, 0, 0, 3, 0, 0, "R6");
    step(1, 1, 0, 0, 3, 0, 0, "R6");
    step(1, 1, 0, 0, 3, 0, 0, "R6");
    step(1, 2, 0, 0, 3, 0, 0, "R7");
    nop("R7");
    step(0, 0, 1, 1, 1, 0, 0, "R8");
    step(0, 0, 1, 1, 3, 0, 0, "R8");
    step(0, 0, 1, 1, 0, 0, 0, "R8");
    step(0, 0, 1, 0, 2, 0, 0, "R8");
    step(0, 0, 1, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 3, 1, 3, "R9");
    step(0, 0, 1, 1, 0, 1, 1, "R9");
    step(1, 3, 1, 0, 0, 1, 2, "R10");
    step(1, 3, 1, 3, 2, 0, 0, "R10");
    // partitioned sharing
    do_reset(1, 0, 4'hF);
    nop("R3");
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 3, 0, 0, "R5");
    step(1, 0, 0, 0, 3, 0, 0, "R7");
    step(1, 1, 0, 0, 3, 0, 0, "R6");
    mask = 4'h3; nop("R3");
    mask = 4'h0; nop("R3");
    mask = 4'h1; nop("R3");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 3, 0, 0, "R6");
    mask = 4'h7; nop("R5");
    mask = 4'hF; nop("R3");
    step(1, 0, 0, 0, 3, 0, 0, "R7");
    // threshold sharing
    do_reset(2, 50, 4'hF);
    nop("R4");
    mask = 4'h1; nop("R4");
    mask = 4'h3; nop("R4");
    mask = 4'h2; nop("R4");
    do_reset(2, 120, 4'hF);
    nop("R4");
    do_reset(2, 37, 4'hF);
    nop("R4");
    step(1, 2, 0, 0, 3, 0, 0, "R5");
    do_reset(3, 37, 4'hF);
    nop("R2");
    mask = 4'h1; nop("R2");
    idle_inputs();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule